// File: doc/BRIEF.md
# One-Shot Protocol Timeout Timer

This block gives a USB On-The-Go controller a one-shot timeout for its protocol timing. Software drives it through one 32-bit register. The top bit arms the timer. The low 27 bits hold the timeout length in ticks of a reference strobe, and that strobe normally runs at 60 MHz. The timeout period is therefore the programmed count divided by 60 MHz.

Every write replaces whatever was in progress. A write with the arm bit set restarts the countdown from the new count. A write with the arm bit clear stops the countdown without an event. When the count runs out, the register clears to zero and the block sends a one-cycle event pulse. The surrounding interrupt controller latches that pulse as a sticky source bit.

The reference strobe comes from outside the block and is a single-cycle enable at the system clock rate.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, `rd_data` reads 0 and `timeout_pulse` is low.
- R2: A write stores all 32 bits of `wr_data`, and `rd_data` shows the stored value from the cycle after the write.
- R3: A write with bit 31 set arms the timer with the count in bits 26:0. A count N of 1 or more expires on the N-th `ref_tick` after the write. A count of 0 expires on the first `ref_tick`.
- R4: A write with bit 31 set while the timer is armed discards the old countdown and restarts from the new count.
- R5: A write with bit 31 clear disarms the timer, and no event follows from the earlier arming.
- R6: On expiry the register reads 0 from the next cycle, and `timeout_pulse` is high for exactly that one cycle.
- R7: Each arming produces at most one pulse. Cycles without `ref_tick` do not advance the countdown, and `rd_data` changes only through a write or an expiry.
- R8: When a write and an expiring `ref_tick` arrive in the same cycle, the write wins and no pulse is produced for the old arming.
- R9: Bits 30:27 are stored and read back, but they do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle reference strobe, one per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value: bit 31 arms, bits 26:0 give the count |
| rd_data | output | 32 | Current register value |
| timeout_pulse | output | 1 | One-cycle expiry event |

## Verification
The hardest case to reach is a write that lands in exactly the cycle in which the final tick would expire the old arming. Random stimulus rarely hits that single cycle. A directed sequence arms the timer with count 1 and then raises `ref_tick` and `wr_en` together. The same sequence is repeated with count 0 and with a cancelling write.

Random traffic keeps the counts small and the tick density varied. This makes expiries, restarts on top of a running countdown, and back-to-back re-arming right after a pulse all occur often.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_CNT_W  = 27;
    localparam int DEF_ARM_BIT = 31;

    // A remaining count at or below one expires on the tick being taken.
    function automatic logic last_tick(input logic [DEF_CNT_W-1:0] rem);
        return rem <= DEF_CNT_W'(1);
    endfunction
endpackage

// File: rtl/otg_tmr_cnt.sv
module otg_tmr_cnt #(
    parameter int CNT_W = otg_tmr_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_arm,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             tick,
    output logic             expire,
    output logic             armed,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] rem;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        expire = 1'b0;
        if (load) begin
            // A write always replaces the countdown.
            st_d.armed = load_arm;
            st_d.rem   = load_cnt;
        end else if (st_q.armed && tick) begin
            if (st_q.rem <= ONE) begin
                expire      = 1'b1;
                st_d.armed  = 1'b0;
                st_d.rem    = '0;
                st_d.pulse  = 1'b1;
            end else begin
                st_d.rem = st_q.rem - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign pulse = st_q.pulse;

    // R7: an event is never followed by another in the next cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R6: after an event the timer is idle
    a_r6_disarmed_after: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> !armed);
    // R5: a cancelling load is never followed by an event
    a_r5_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_arm) |=> !pulse);
    // R7: without a tick the remaining count holds
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(st_q.rem));
endmodule

// File: rtl/otg_tmr_reg.sv
module otg_tmr_reg #(
    parameter int DATA_W = otg_tmr_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = wr_data;
        end else if (clr) begin
            st_d.val = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;

    // R2: every written word is read back whole
    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_data));
    // R6: expiry without a competing write leaves zero
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> value == '0);
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer #(
    parameter int DATA_W  = otg_tmr_pkg::DEF_DATA_W,
    parameter int CNT_W   = otg_tmr_pkg::DEF_CNT_W,
    parameter int ARM_BIT = otg_tmr_pkg::DEF_ARM_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_pulse
);
    logic expire;
    logic armed;

    otg_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .load_arm (wr_data[ARM_BIT]),
        .load_cnt (wr_data[CNT_W-1:0]),
        .tick     (ref_tick),
        .expire   (expire),
        .armed    (armed),
        .pulse    (timeout_pulse)
    );

    otg_tmr_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr     (expire),
        .value   (rd_data)
    );

    // R6: the event cycle always shows a zero register
    a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> rd_data == '0);
    // R7: the register moves only by a write or an expiry
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_data == $past(rd_data)) || timeout_pulse);
    // R8: a write in the expiring cycle suppresses the event
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !timeout_pulse);
    // R3: an event needs a prior arming
    a_r3_armed_before: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !wr_en) |=> !timeout_pulse);
endmodule

// File: tb/otg_timeout_timer_bench.sv
module otg_timeout_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        timeout_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    logic [31:0] m_reg = '0;
    logic        m_arm = 1'b0;
    logic [26:0] m_rem = '0;
    logic        m_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otg_timeout_timer u_otg_timeout_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_tick      (ref_tick),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .timeout_pulse (timeout_pulse)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > MAX_CYCLES) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, MAX_CYCLES);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic is_last(input logic [26:0] rem);
        return rem <= 27'd1;
    endfunction

    task automatic check(input string tag);
        checks = checks + 1;
        if (rd_data !== m_reg || timeout_pulse !== m_pulse) begin
            errors = errors + 1;
            $display("FAIL %s: actual rd=%h pulse=%b expected rd=%h pulse=%b",
                     tag, rd_data, timeout_pulse, m_reg, m_pulse);
        end
    endtask

    // One clock cycle: drive at negedge, model the edge, check after it.
    task automatic step(input logic w, input logic [31:0] d, input logic t, input string tag);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        ref_tick = t;
        m_pulse = 1'b0;
        if (w) begin
            m_reg = d;
            m_arm = d[31];
            m_rem = d[26:0];
        end else if (m_arm && t) begin
            if (is_last(m_rem)) begin
                m_reg = '0;
                m_arm = 1'b0;
                m_pulse = 1'b1;
            end else begin
                m_rem = m_rem - 27'd1;
            end
        end
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic idle(input int n, input logic t, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, t, tag);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        checks = checks + 1;
        if (rd_data !== 32'h0 || timeout_pulse !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1: actual rd=%h pulse=%b expected rd=0 pulse=0", rd_data, timeout_pulse);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: plain store with arm clear
        step(1'b1, 32'h1234_5678, 1'b0, "R2");
        idle(3, 1'b1, "R2");
        // R3: count 3 expires on third tick, gaps without ticks hold
        step(1'b1, 32'h8000_0003, 1'b0, "R3");
        idle(2, 1'b0, "R7");
        idle(4, 1'b1, "R3");
        // R3: count zero expires on first tick
        step(1'b1, 32'h8000_0000, 1'b0, "R3");
        idle(2, 1'b1, "R6");
        // R4: restart mid-countdown
        step(1'b1, 32'h8000_0005, 1'b0, "R4");
        idle(3, 1'b1, "R4");
        step(1'b1, 32'h8000_0004, 1'b1, "R4");
        idle(6, 1'b1, "R4");
        // R5: cancel
        step(1'b1, 32'h8000_0002, 1'b0, "R5");
        step(1'b0, '0, 1'b1, "R5");
        step(1'b1, 32'h0000_0002, 1'b1, "R5");
        idle(5, 1'b1, "R5");
        // R8: write lands on the expiring tick
        step(1'b1, 32'h8000_0001, 1'b0, "R8");
        step(1'b1, 32'h8000_0002, 1'b1, "R8");
        idle(3, 1'b1, "R8");
        step(1'b1, 32'h8000_0000, 1'b0, "R8");
        step(1'b1, 32'h0000_0000, 1'b1, "R8");
        idle(2, 1'b1, "R8");
        // R9: upper bits stored, count unaffected
        step(1'b1, 32'hF800_0002, 1'b0, "R9");
        idle(3, 1'b1, "R9");
        // R7: re-arm right after a pulse gives a fresh single event
        step(1'b1, 32'h8000_0001, 1'b0, "R7");
        step(1'b0, '0, 1'b1, "R7");
        step(1'b1, 32'h8000_0001, 1'b1, "R7");
        idle(3, 1'b1, "R7");

        // Random traffic: small counts, varied tick density
        for (int i = 0; i < 20000; i++) begin
            logic        w;
            logic [31:0] d;
            logic        t;
            w = ($urandom % 12) == 0;
            d = $urandom;
            d[26:0] = 27'($urandom % 9);
            if (($urandom % 4) != 0) d[31] = 1'b1;
            t = ($urandom % ((i / 5000) + 2)) == 0;
            step(w, d, t, "R3/R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule